// File: doc/BRIEF.md
# Carry-Skip Ripple Adder

This block adds two 16-bit operands and a carry-in within one combinational path. It returns a 16-bit sum and a carry-out. The operand bits are divided into four groups of four: bits 0 to 3, 4 to 7, 8 to 11 and 12 to 15. Inside a group, the carry ripples from bit to bit. Each group also has a shortcut. When every bit of the group would pass a carry through, a two-way selector sends the group's incoming carry directly to the next group. In that case the carry does not wait for the ripple chain.

For each bit, a small cell sorts the bit position into one of three classes. A bit either creates a carry (both operand bits set), passes a carry (exactly one operand bit set), or absorbs a carry (neither operand bit set). The ripple chain and the sum bits use the create and pass signals. The AND of the four pass signals in a group is the select input of that group's skip selector. The block has no state and no clock. It is used wherever a plain binary add is needed and a shorter worst-case carry path is wanted than a flat 16-bit ripple gives.

The design follows the project's layout conventions. However, the block has no states, so the brief names no states or transitions.

Top module: `csk_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals the 17-bit value `a_in + b_in + carry_in` for every combination of inputs.
- R2: A carry leaving one group of four bits enters the next higher group. Example: operands 0x000F and 0x0001 with carry-in 0 give sum 0x0010 and carry-out 0.
- R3: When `a_in ^ b_in` is all ones within a group, the carry leaving that group equals the carry entering it. With `a_in ^ b_in` = 0xFFFF, `carry_out` equals `carry_in` and the sum is 0xFFFF (carry-in 0) or 0x0000 (carry-in 1). A carry-in of 1 with operands 0x0FFF and 0x0000 gives sum 0x1000, having crossed three groups.
- R4: When every bit creates a carry (both operands 0xFFFF), `carry_out` is 1 and the sum is 0xFFFE with bit 0 equal to `carry_in`.
- R5: When every bit absorbs a carry (both operands 0x0000), `carry_out` is 0 and the sum is `carry_in` in bit 0 with all other bits zero.
- R6: Each bit position is in exactly one class: create (a AND b), pass (a XOR b) or absorb (NOT a AND NOT b).
- R7: Sum bit i equals the pass signal of bit i XOR the carry entering bit i. A single set bit in one operand, with the other operand zero and no carry-in, appears unchanged at the sum.
- R8: The ripple carry of a group and the output of its skip selector always agree. The choice of path never changes the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15, taken from the last group's skip selector |

## Verification
In one evaluation, a group can both ripple a carry through its four pass bits and forward the same carry through its skip selector. Both paths are live for the same input. These collisions are provoked in three ways: by operands whose XOR is all ones in one or more groups, by an exhaustive sweep of every operand nibble pair and carry-in in each group position, and by background bits that feed carries into the swept group. Every result is judged against the arithmetic sum computed in the bench. An in-design check also confirms that the two carry paths never disagree.

// File: rtl/csk_pkg.sv
package csk_pkg;

    typedef struct packed {
        logic gen;
        logic prp;
        logic kil;
    } bit_class_t;

endpackage

// File: rtl/csk_class_cell.sv
module csk_class_cell
    import csk_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    output bit_class_t cls
);

    always_comb begin
        cls.gen = a_bit & b_bit;
        cls.prp = a_bit ^ b_bit;
        cls.kil = ~a_bit & ~b_bit;
    end

    // R6: a bit position sits in exactly one class
    always_comb begin
        p_one_class_r6: assert ($countones({cls.gen, cls.prp, cls.kil}) == 1)
            else $error("R6 bit class not unique");
    end

endmodule

// File: rtl/csk_group.sv
module csk_group
    import csk_pkg::*;
#(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] a_grp,
    input  logic [GRP-1:0] b_grp,
    input  logic           c_grp_in,
    output logic [GRP-1:0] s_grp,
    output logic           c_grp_out
);

    bit_class_t       cls [GRP];
    logic [GRP-1:0]   prp_v;
    logic [GRP-1:0]   gen_v;
    logic             ripple_c;
    logic             all_prp;

    for (genvar i = 0; i < GRP; i++) begin : g_cell
        csk_class_cell i_cell (
            .a_bit (a_grp[i]),
            .b_bit (b_grp[i]),
            .cls   (cls[i])
        );
        assign prp_v[i] = cls[i].prp;
        assign gen_v[i] = cls[i].gen;
    end

    // ripple chain and sum generation
    always_comb begin
        logic rc;
        rc = c_grp_in;
        for (int i = 0; i < GRP; i++) begin
            s_grp[i] = prp_v[i] ^ rc;
            rc       = gen_v[i] | (prp_v[i] & rc);
        end
        ripple_c = rc;
    end

    // skip selector
    assign all_prp   = &prp_v;
    assign c_grp_out = all_prp ? c_grp_in : ripple_c;

    // R3: an all-pass group hands its input carry straight on
    // R8: skip path and ripple path agree
    always_comb begin
        if (all_prp) begin
            p_skip_pass_r3: assert (c_grp_out == c_grp_in)
                else $error("R3 skip carry mismatch");
        end
        p_paths_agree_r8: assert (ripple_c == c_grp_out)
            else $error("R8 ripple and skip carries differ");
    end

endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
    parameter int WIDTH = 16,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NGRP = WIDTH / GRP;

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        logic c_i;
        logic c_o;
        if (j == 0) begin : g_first
            assign c_i = carry_in;
        end else begin : g_next
            assign c_i = g_grp[j-1].c_o;
        end
        csk_group #(.GRP(GRP)) i_group (
            .a_grp     (a_in[j*GRP +: GRP]),
            .b_grp     (b_in[j*GRP +: GRP]),
            .c_grp_in  (c_i),
            .s_grp     (sum_out[j*GRP +: GRP]),
            .c_grp_out (c_o)
        );
    end

    assign carry_out = g_grp[NGRP-1].c_o;

    // R1: the full result matches binary addition
    always_comb begin
        p_sum_total_r1: assert ({carry_out, sum_out} ==
                                ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in}))
            else $error("R1 sum mismatch");
    end

endmodule

// File: tb/test_csk_adder.sv
module test_csk_adder;

    logic        clk = 1'b0;
    logic [15:0] a_in;
    logic [15:0] b_in;
    logic        carry_in;
    logic [15:0] sum_out;
    logic        carry_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_2B3D;

    always #2.5 clk = ~clk;

    csk_adder i_csk_adder (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic c, input string req);
        logic [16:0] exp;
        @(posedge clk);
        a_in = a; b_in = b; carry_in = c;
        @(negedge clk);
        exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
        checks++;
        if ({carry_out, sum_out} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h c=%b actual=%h expected=%h",
                     req, a, b, c, {carry_out, sum_out}, exp);
        end
    endtask

    initial begin
        a_in = '0; b_in = '0; carry_in = 1'b0;
        // R5: all absorb, both carry-in values
        apply(16'h0000, 16'h0000, 1'b0, "R5");
        apply(16'h0000, 16'h0000, 1'b1, "R5");
        // R4: all create
        apply(16'hFFFF, 16'hFFFF, 1'b0, "R4");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R4");
        // R3: all pass, skip through every group
        apply(16'hFFFF, 16'h0000, 1'b0, "R3");
        apply(16'hFFFF, 16'h0000, 1'b1, "R3");
        apply(16'hA5C3, 16'h5A3C, 1'b1, "R3");
        apply(16'h0FFF, 16'h0000, 1'b1, "R3");
        apply(16'hF0F0, 16'h0F0F, 1'b1, "R3");
        // R2: carry crossing group boundaries by ripple
        apply(16'h000F, 16'h0001, 1'b0, "R2");
        apply(16'h00F8, 16'h0008, 1'b0, "R2");
        apply(16'h0800, 16'h0800, 1'b1, "R2");
        apply(16'h7FFF, 16'h0001, 1'b0, "R2");
        // R7: single set bit passes unchanged
        for (int i = 0; i < 16; i++) begin
            apply(16'(1 << i), 16'h0000, 1'b0, "R7");
            apply(16'h0000, 16'(1 << i), 1'b0, "R7");
        end
        // R6 / R8: exhaustive nibble sweep in every group position
        for (int g = 0; g < 4; g++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [15:0] msk;
                        logic [15:0] av;
                        logic [15:0] bv;
                        lfsr = step(lfsr);
                        msk  = ~(16'hF << (4 * g));
                        av   = (lfsr[15:0] & msk) | 16'(x << (4 * g));
                        bv   = (lfsr[31:16] & msk) | 16'(y << (4 * g));
                        apply(av, bv, c[0], "R6/R8");
                    end
                end
            end
        end
        // R1: random operands
        for (int n = 0; n < 4000; n++) begin
            lfsr = step(lfsr);
            apply(lfsr[15:0], lfsr[31:16], lfsr[7] ^ lfsr[20], "R1");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule